// File: doc/BRIEF.md
# Dual-Protocol Write-Only Control Register Bank

This block is the slave side of the configuration port of a mixed-signal front end. A bank of fourteen 8-bit control registers drives gain, clamp, PLL and clock-phase settings as parallel outputs. The register bytes are decoded by neighbouring logic. One example is a 7-bit coarse gain and a 5-bit fine gain per colour channel. Another is a pair of 5-bit phase selectors, where each of the 32 steps is 11.25 degrees. The registers are write-only. Nothing can be read back.

A quasi-static mode pin selects how writes arrive. The first choice is a two-wire I2C-style bus with start/stop framing, a 7-bit slave address and acknowledge. The second choice is a three-wire serial bus framed by a select-enable line. Both front ends feed the same decoder. In each frame, the first byte after the address is a subaddress. It names a single register, or it carries a reserved code that loads the whole bank in ascending order. A disable pin turns the entire port off.

Serial clock, data and select pass through two-flop synchronizers into the system clock domain. The path from the front ends to the register bank is a one-cycle event with no back-pressure, because a serial master cannot be stalled: every decoded byte is consumed in the cycle it appears. The mode pin and the disable pin are treated as synchronous to the system clock.

Top module: `scfg_bank`

## Requirements
- R1: Reset sets register n (0 to 13) to the value 0x40 + 3*n and leaves SDA released (`sda_pull` low).
- R2: With `proto_sel` high, only two-wire traffic is decoded. With it low, only three-wire traffic is decoded. Traffic in the unselected protocol changes no register and is not acknowledged.
- R3: While `port_off` is high, bus activity changes no register and no acknowledge is driven.
- R4: Two-wire address byte, sent MSB first: {1,0,0,1,1,`addr_pin[1]`,`addr_pin[0]`} followed by a direction bit, where 0 means write. A matching write address is acknowledged by asserting `sda_pull` during the ninth SCL clock.
- R5: A non-matching address, or a matching address with the direction bit set to 1 (read), is not acknowledged. Every byte up to the next start condition is then ignored.
- R6: After an acknowledged address, each data byte is acknowledged during its ninth clock.
- R7: Normal mode: the subaddress byte (value 0 to 13) is followed by one data byte. That byte writes only the addressed register. Any further bytes in the same frame are ignored.
- R8: A subaddress above 13 whose low five bits are not 11111 is accepted, but the data that follow it are discarded.
- R9: A subaddress whose low five bits are 11111 (upper three bits ignored) enters sequential mode. The following data bytes go to registers 0, 1, 2 and onward up to 13. Bytes after register 13 are ignored until the frame ends.
- R10: Three-wire mode: a frame lasts while `sel_in` is high. Bits are sampled on rising `scl_in` edges, MSB first. The first byte is the subaddress and the bytes after it are data, decoded as in R7 to R9.
- R11: A register output keeps its old value up to the rising serial clock edge that carries the last data bit. It shows the new value no more than six system clocks after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| proto_sel | input | 1 | 1 selects two-wire, 0 selects three-wire |
| port_off | input | 1 | High disables the whole serial port |
| addr_pin | input | 2 | Low two bits of the two-wire slave address |
| scl_in | input | 1 | Serial clock, shared by both protocols |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sel_in | input | 1 | Three-wire select enable, active high |
| sda_pull | output | 1 | 1 drives SDA low (acknowledge), open-drain style |
| cfg_q | output | 112 | Register n occupies bits [8n+7:8n] |

## Verification
A wrong subaddress pointer or a stale sequential flag shows up as the wrong register changing, or too many registers changing. The bench compares the whole bank after every frame, so such an error appears within one transaction. A broken address comparison or acknowledge phase shows as a missing or extra `sda_pull` in the ninth clock of that same byte. Errors in the synchronizer or the edge detection either shift data bits, which corrupts the written value, or move the update instant. The bench catches the second case by sampling the bank just before and a few cycles after the final data edge.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  localparam int NREG = 14;
  localparam int DW   = 8;
  localparam int PW   = $clog2(NREG + 1);
  localparam logic [4:0] SEQ_CODE = 5'h1F;

  // one-cycle event from a serial front end to the register bank
  typedef struct packed {
    logic          frm;   // new frame begins
    logic          bv;    // byte valid
    logic [DW-1:0] b;     // received byte
  } scfg_ev_t;

  function automatic logic [DW-1:0] reg_reset(int n);
    return DW'(8'h40 + 3 * n);
  endfunction
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '1;
      q    <= '1;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/scfg_i2c_rx.sv
module scfg_i2c_rx
  import scfg_pkg::*;
#(
  parameter logic [4:0] DEV_ID = 5'b10011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] addr_pin,
  input  logic       scl_s,
  input  logic       sda_s,
  output scfg_ev_t   ev,
  output logic       sda_pull
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_ACK, S_SKIP} st_t;

  st_t        st;
  logic       scl_q, sda_q;
  logic [6:0] sh;
  logic [2:0] cnt;

  logic scl_rise, scl_fall, start_c, stop_c, addr_hit;
  logic [7:0] rx_byte;

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  assign rx_byte  = {sh, sda_s};
  assign addr_hit = (rx_byte[7:1] == {DEV_ID, addr_pin}) && !rx_byte[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      sh       <= '0;
      cnt      <= '0;
      ev       <= '0;
      sda_pull <= 1'b0;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
      ev    <= '0;
      if (!en) begin
        st       <= S_IDLE;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else if (start_c) begin
        st       <= S_ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else if (stop_c) begin
        st       <= S_IDLE;
        sda_pull <= 1'b0;
      end else begin
        unique case (st)
          S_ADDR: if (scl_rise) begin
            sh  <= rx_byte[6:0];
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              if (addr_hit) begin
                st     <= S_ACK;
                ev.frm <= 1'b1;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          S_DATA: if (scl_rise) begin
            sh  <= rx_byte[6:0];
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              ev.bv <= 1'b1;
              ev.b  <= rx_byte;
              st    <= S_ACK;
            end
          end
          S_ACK: if (scl_fall) begin
            if (!sda_pull) sda_pull <= 1'b1;
            else begin
              sda_pull <= 1'b0;
              st       <= S_DATA;
              cnt      <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R6
  ack_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(scl_fall));

  // R3
  off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sda_pull);
endmodule

// File: rtl/scfg_3w_rx.sv
module scfg_3w_rx
  import scfg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     scl_s,
  input  logic     sda_s,
  input  logic     sel_s,
  output scfg_ev_t ev
);
  logic       scl_q, active;
  logic [6:0] sh;
  logic [2:0] cnt;
  logic       scl_rise;

  assign scl_rise = scl_s & ~scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      active <= 1'b0;
      sh     <= '0;
      cnt    <= '0;
      ev     <= '0;
    end else begin
      scl_q <= scl_s;
      ev    <= '0;
      if (!en || !sel_s) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (!active) begin
        active <= 1'b1;
        cnt    <= '0;
        ev.frm <= 1'b1;
      end else if (scl_rise) begin
        sh  <= {sh[5:0], sda_s};
        cnt <= cnt + 3'd1;
        if (cnt == 3'd7) begin
          ev.bv <= 1'b1;
          ev.b  <= {sh, sda_s};
        end
      end
    end
  end

  // R10
  byte_in_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev.bv |-> $past(sel_s));
endmodule

// File: rtl/scfg_regfile.sv
module scfg_regfile
  import scfg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  scfg_ev_t            ev,
  output logic [NREG*DW-1:0]  cfg_q
);
  logic [DW-1:0] regs [NREG];
  logic          have_sub, seq, armed;
  logic [PW-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= reg_reset(i);
      have_sub <= 1'b0;
      seq      <= 1'b0;
      armed    <= 1'b0;
      ptr      <= '0;
    end else if (ev.frm) begin
      have_sub <= 1'b0;
      seq      <= 1'b0;
      armed    <= 1'b0;
    end else if (ev.bv) begin
      if (!have_sub) begin
        have_sub <= 1'b1;
        if (ev.b[4:0] == SEQ_CODE) begin
          seq   <= 1'b1;
          ptr   <= '0;
          armed <= 1'b1;
        end else begin
          seq   <= 1'b0;
          ptr   <= ev.b[PW-1:0];
          armed <= (int'(ev.b) < NREG);
        end
      end else if (armed) begin
        regs[ptr] <= ev.b;
        if (seq) begin
          ptr   <= ptr + 1'b1;
          armed <= (int'(ptr) + 1) < NREG;
        end else begin
          armed <= 1'b0;
        end
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign cfg_q[g*DW +: DW] = regs[g];
  end

  // R7
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev.bv |=> $stable(cfg_q));

  // R8
  armed_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (int'(ptr) < NREG));

  // R9
  seq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq |-> (int'(ptr) <= NREG));
endmodule

// File: rtl/scfg_bank.sv
module scfg_bank
  import scfg_pkg::*;
#(
  parameter logic [4:0] DEV_ID = 5'b10011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               proto_sel,
  input  logic               port_off,
  input  logic [1:0]         addr_pin,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic               sel_in,
  output logic               sda_pull,
  output logic [NREG*DW-1:0] cfg_q
);
  logic [2:0] pins_s;
  scfg_ev_t   ev_i2c, ev_3w, ev;
  logic       en_i2c, en_3w;

  assign en_i2c = !port_off &&  proto_sel;
  assign en_3w  = !port_off && !proto_sel;

  scfg_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({scl_in, sda_in, sel_in}),
    .q(pins_s)
  );

  scfg_i2c_rx #(.DEV_ID(DEV_ID)) u_i2c (
    .clk(clk), .rst_n(rst_n), .en(en_i2c), .addr_pin(addr_pin),
    .scl_s(pins_s[2]), .sda_s(pins_s[1]), .ev(ev_i2c), .sda_pull(sda_pull)
  );

  scfg_3w_rx u_3w (
    .clk(clk), .rst_n(rst_n), .en(en_3w),
    .scl_s(pins_s[2]), .sda_s(pins_s[1]), .sel_s(pins_s[0]), .ev(ev_3w)
  );

  always_comb begin
    if (port_off)       ev = '0;
    else if (proto_sel) ev = ev_i2c;
    else                ev = ev_3w;
  end

  scfg_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .ev(ev), .cfg_q(cfg_q)
  );

  // R3
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_off && $past(port_off)) |=> $stable(cfg_q));

  // R2
  wire_mode_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!proto_sel && $past(!proto_sel)) |-> !sda_pull);
endmodule

// File: tb/scfg_bank_bench.sv
module scfg_bank_bench;
  localparam int NR = 14;
  localparam int Q  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic proto = 1'b1, off = 1'b0;
  logic [1:0] pins = 2'd0;
  logic m_scl = 1'b1, m_sda = 1'b1, m_sel = 1'b0;
  logic sda_pull;
  logic [NR*8-1:0] cfg_q;
  wire  sda_line = m_sda & ~sda_pull;

  always #2.5 clk = ~clk;

  scfg_bank u_scfg_bank (
    .clk(clk), .rst_n(rst_n), .proto_sel(proto), .port_off(off),
    .addr_pin(pins), .scl_in(m_scl), .sda_in(sda_line), .sel_in(m_sel),
    .sda_pull(sda_pull), .cfg_q(cfg_q)
  );

  logic [7:0] model [NR];
  logic [7:0] pl [20];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  function automatic logic [7:0] dflt(int n);
    return 8'(8'h40 + 3 * n);
  endfunction

  function automatic logic [7:0] rd(int n);
    return cfg_q[n*8 +: 8];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cmp_bank(string req);
    int bad = -1;
    for (int r = 0; r < NR; r++) if (bad < 0 && rd(r) !== model[r]) bad = r;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, rd(bad), model[bad]);
  endtask

  task automatic half;
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start;
    m_sda = 1'b1; m_scl = 1'b1; half;
    m_sda = 1'b0; half;
    m_scl = 1'b0; half;
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; half;
    m_scl = 1'b1; half;
    m_sda = 1'b1; half;
  endtask

  task automatic i2c_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; half;
      m_scl = 1'b1; half;
      m_scl = 1'b0;
    end
    m_sda = 1'b1; half;
    m_scl = 1'b1;
    repeat (2) @(negedge clk);
    ack = !sda_line;
    repeat (Q - 2) @(negedge clk);
    m_scl = 1'b0;
  endtask

  task automatic tw_bit(input logic b);
    m_sda = b; half;
    m_scl = 1'b1; half;
    m_scl = 1'b0;
  endtask

  task automatic tw_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) tw_bit(b[i]);
  endtask

  // addr byte then pl[0..n-1]; ack expectation checked on every byte
  task automatic send(input bit use_i2c, input logic [7:0] abyte, input int n,
                      input bit exp_ack, input string req);
    bit a;
    if (use_i2c) begin
      i2c_start;
      i2c_byte(abyte, a);
      chk(a == exp_ack, req, a, exp_ack);
      for (int k = 0; k < n; k++) begin
        i2c_byte(pl[k], a);
        chk(a == exp_ack, req, a, exp_ack);
      end
      i2c_stop;
    end else begin
      m_scl = 1'b0; m_sel = 1'b1; half;
      for (int k = 0; k < n; k++) tw_byte(pl[k]);
      half; m_sel = 1'b0; half;
      m_scl = 1'b1;
    end
    repeat (4 * Q) @(negedge clk);
  endtask

  task automatic model_apply(int n);
    if (pl[0][4:0] == 5'h1F) begin
      for (int k = 1; k < n; k++) if (k - 1 < NR) model[k-1] = pl[k];
    end else if (pl[0] < NR && n > 1) begin
      model[pl[0]] = pl[1];
    end
  endtask

  function automatic logic [7:0] abyte_of(logic [1:0] p, bit rw);
    return {5'b10011, p, rw};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int kind, n;
    bit use_i2c, exp_ack, eff;
    logic [7:0] ab;
    string req;
    seed = $urandom(32'd4711);
    for (int r = 0; r < NR; r++) model[r] = dflt(r);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset values and released SDA
    cmp_bank("R1");
    chk(sda_pull == 1'b0, "R1 sda released", sda_pull, 0);

    // R4 / R6 / R7: each address pin combination, directed write
    for (int p = 0; p < 4; p++) begin
      pins = 2'(p);
      pl[0] = 8'(p + 2); pl[1] = 8'(8'hA0 + p);
      send(1'b1, abyte_of(pins, 1'b0), 2, 1'b1, "R4 R6 ack");
      model_apply(2);
      cmp_bank("R7 directed");
    end

    // R11: update instant in three-wire mode
    proto = 1'b0;
    repeat (4) @(negedge clk);
    m_scl = 1'b0; m_sel = 1'b1; half;
    tw_byte(8'h05);
    for (int i = 7; i >= 1; i--) tw_bit(8'hC3 >> i);
    m_sda = 1'b1; half;
    chk(rd(5) == model[5], "R11 before last edge", rd(5), model[5]);
    m_scl = 1'b1;
    @(negedge clk);
    chk(rd(5) == model[5], "R11 right after edge", rd(5), model[5]);
    repeat (5) @(negedge clk);
    model[5] = 8'hC3;
    chk(rd(5) == 8'hC3, "R11 after six clocks", rd(5), 8'hC3);
    half; m_scl = 1'b0; half; m_sel = 1'b0; half; m_scl = 1'b1;
    repeat (4 * Q) @(negedge clk);

    // R10 / R9: full sequential load over three wires with overflow bytes
    pl[0] = 8'hFF;
    for (int k = 1; k < 17; k++) pl[k] = 8'(k * 7 + 1);
    send(1'b0, 8'h00, 17, 1'b0, "R10");
    model_apply(17);
    cmp_bank("R9 R10 sequential");

    // random mix
    for (int it = 0; it < 30; it++) begin
      kind  = $urandom % 7;
      proto = ($urandom % 2) != 0;
      if (kind == 3 || kind == 4) proto = 1'b1;
      pins  = 2'($urandom % 4);
      off   = (kind == 5);
      repeat (4) @(negedge clk);
      use_i2c = (kind == 6) ? !proto : proto;
      ab = abyte_of(pins, 1'b0);
      n  = 2;
      for (int k = 0; k < 20; k++) pl[k] = 8'($urandom);
      case (kind)
        0: begin pl[0] = 8'($urandom % NR); n = 2 + $urandom % 2; req = "R7 normal"; end
        1: begin
             do pl[0] = 8'(NR + $urandom % (256 - NR)); while (pl[0][4:0] == 5'h1F);
             req = "R8 out of range";
           end
        2: begin pl[0] = {3'($urandom), 5'h1F}; n = 2 + $urandom % 18; req = "R9 sequential"; end
        3: begin pl[0] = 8'($urandom % NR); ab = abyte_of(~pins, 1'b0); req = "R5 mismatch"; end
        4: begin pl[0] = 8'($urandom % NR); ab = abyte_of(pins, 1'b1); req = "R5 read"; end
        5: begin pl[0] = 8'($urandom % NR); req = "R3 disabled"; end
        default: begin pl[0] = 8'($urandom % NR); req = "R2 wrong protocol"; end
      endcase
      eff     = (kind <= 2);
      exp_ack = use_i2c && eff;
      send(use_i2c, ab, n, exp_ack, req);
      if (eff) model_apply(n);
      cmp_bank(req);
      off = 1'b0;
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule